// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers up to thirty-two level-sensitive interrupt requests and presents them to a parent controller as one combined interrupt line. Each source has one bit in a latched cause register and one bit in an enable register. A source that is high at a clock edge sets its cause bit. Software acknowledges a request by writing a one to that bit. A line takes part in the combined interrupt only while its enable bit is set.

Alongside the combined line, the block reports the index of the lowest-numbered source that is both latched and enabled, with a flag that marks the index as meaningful. A handler in the parent can then service lines in ascending order without scanning registers. Software reaches the two registers through a small synchronous 32-bit read/write port. The port decodes word offsets and returns read data one cycle after the request.

Top module: `cic_top`

## Requirements
- R1: A synchronous active-high reset clears the cause register, the enable register, `irq_out`, `irq_id_valid`, `irq_id` and `bus_rdata` to zero.
- R2: A source that is high at a rising edge sets its cause bit at that edge, whatever its enable bit holds. The bit stays set after the source drops, and a read of the cause register returns the raw latched bits.
- R3: A write to word offset 0x00 (cause) clears each cause bit whose write-data bit is 1 and leaves each bit written as 0 unchanged.
- R4: A write to word offset 0x04 (enable) replaces the whole enable register with the write data, and a read of offset 0x04 returns it. A 1 bit enables its line.
- R5: `irq_out` is a register loaded at every edge with the OR of (cause AND enable). It rises one edge after the first enabled cause bit is latched and stays high while any enabled bit remains latched.
- R6: `irq_id` gives the lowest bit position set in (cause AND enable), registered on the same edge as `irq_out`. `irq_id_valid` is high exactly when that set is non-empty, and `irq_id` is 0 whenever it is empty.
- R7: When a cause bit is cleared by a write in the same cycle that its source is high, the set wins and the bit stays 1.
- R8: Writing 0 to the enable register and then all ones to the cause register, with every source low, leaves both registers zero and drops `irq_out`.
- R9: Bits [1:0] of the address are ignored. A write to any word offset other than 0x00 or 0x04 changes no register, and a read of such an offset returns 0.
- R10: `bus_rdata` is loaded only at an edge where a read is requested (`bus_sel` high, `bus_wr` low) and holds its value at every other edge, including edges that carry writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Level-sensitive request lines, bit n is source n |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, valid the cycle after a read |
| irq_out | output | 1 | Combined interrupt toward the parent controller |
| irq_id | output | 5 | Lowest enabled pending source index |
| irq_id_valid | output | 1 | High when irq_id names a pending source |

## Verification
A source update and a software acknowledge can land on the cause register in the same cycle. The bench provokes this by holding a source high while it writes a one to that source's cause bit. It then reads the register back and expects the bit still set (R7). The bench also checks the opposite case: a bit whose source has already dropped must clear on the same kind of write (R3). A mask write can coincide with a pending cause as well. For that case the bench expects `irq_out` and `irq_id` to react exactly one edge after the enable register changes.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Byte address width of the register port; bits [1:0] select a byte lane.
    localparam int ADDR_W = 4;
    localparam int WSEL_W = ADDR_W - 2;

    // Word selects; the parent driver depends on these offsets.
    localparam logic [WSEL_W-1:0] WSEL_CAUSE  = WSEL_W'(0);
    localparam logic [WSEL_W-1:0] WSEL_ENABLE = WSEL_W'(1);

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_CAUSE  = 2'd1,
        TGT_ENABLE = 2'd2
    } tgt_e;

    typedef struct packed {
        logic rd;
        logic wr;
        tgt_e tgt;
    } acc_t;

    function automatic tgt_e decode_target(input logic [ADDR_W-1:0] addr);
        logic [WSEL_W-1:0] wsel;
        wsel = addr[ADDR_W-1:2];
        if (wsel == WSEL_CAUSE)
            return TGT_CAUSE;
        else if (wsel == WSEL_ENABLE)
            return TGT_ENABLE;
        return TGT_NONE;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cic_bus_decode.sv
module cic_bus_decode
    import cic_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    always_comb begin
        acc.rd  = sel && !wr;
        acc.wr  = sel && wr;
        acc.tgt = decode_target(addr);
    end
endmodule

// File: rtl/cic_cause_bank.sv
module cic_cause_bank #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            clr_en,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] cause_q
);
    // One latch cell per source: set has priority over a same-cycle clear.
    for (genvar n = 0; n < NSRC; n++) begin : g_cell
        logic clear_now;
        assign clear_now = clr_en && clr_bits[n];
        always_ff @(posedge clk) begin
            if (rst)
                cause_q[n] <= 1'b0;
            else if (src_req[n])
                cause_q[n] <= 1'b1;
            else if (clear_now)
                cause_q[n] <= 1'b0;
        end
    end
endmodule

// File: rtl/cic_enable_reg.sv
module cic_enable_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] enable_q
);
    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '0;
        else if (wr_en)
            enable_q <= wdata;
    end
endmodule

// File: rtl/cic_lowest_finder.sv
module cic_lowest_finder #(
    parameter int NSRC = 32,
    localparam int IW  = cic_pkg::idx_width(NSRC)
) (
    input  logic [NSRC-1:0] vec,
    output logic            found,
    output logic [IW-1:0]   index
);
    // Heap-ordered binary tree: leaves at NSRC..2*NSRC-1, root at 1.
    // NSRC must be a power of two.
    logic          nv [1:2*NSRC-1];
    logic [IW-1:0] ni [1:2*NSRC-1];

    for (genvar j = 0; j < NSRC; j++) begin : g_leaf
        assign nv[NSRC+j] = vec[j];
        assign ni[NSRC+j] = IW'(j);
    end

    for (genvar k = 1; k < NSRC; k++) begin : g_node
        // Left child covers the lower indices, so it wins when set.
        assign nv[k] = nv[2*k] | nv[2*k+1];
        assign ni[k] = nv[2*k] ? ni[2*k] : ni[2*k+1];
    end

    assign found = nv[1];
    assign index = nv[1] ? ni[1] : '0;
endmodule

// File: rtl/cic_top.sv
module cic_top
    import cic_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int IW  = idx_width(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_out,
    output logic [IW-1:0]     irq_id,
    output logic              irq_id_valid
);
    acc_t            acc;
    logic [NSRC-1:0] cause_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] eff;
    logic            eff_any;
    logic [IW-1:0]   eff_idx;
    logic            clr_en;
    logic            mask_wr;

    cic_bus_decode u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .acc  (acc)
    );

    assign clr_en  = acc.wr && (acc.tgt == TGT_CAUSE);
    assign mask_wr = acc.wr && (acc.tgt == TGT_ENABLE);

    cic_cause_bank #(.NSRC(NSRC)) u_cause (
        .clk      (clk),
        .rst      (rst),
        .src_req  (src_req),
        .clr_en   (clr_en),
        .clr_bits (bus_wdata),
        .cause_q  (cause_q)
    );

    cic_enable_reg #(.NSRC(NSRC)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (mask_wr),
        .wdata    (bus_wdata),
        .enable_q (mask_q)
    );

    assign eff = cause_q & mask_q;

    cic_lowest_finder #(.NSRC(NSRC)) u_find (
        .vec   (eff),
        .found (eff_any),
        .index (eff_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out      <= 1'b0;
            irq_id_valid <= 1'b0;
            irq_id       <= '0;
        end else begin
            irq_out      <= eff_any;
            irq_id_valid <= eff_any;
            irq_id       <= eff_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (acc.rd) begin
            unique case (acc.tgt)
                TGT_CAUSE:  bus_rdata <= cause_q;
                TGT_ENABLE: bus_rdata <= mask_q;
                default:    bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/cic_checker.sv
module cic_checker
    import cic_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int IW  = idx_width(NSRC)
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_req,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   bus_rdata,
    input logic              irq_out,
    input logic [IW-1:0]     irq_id,
    input logic              irq_id_valid,
    input logic [NSRC-1:0]   cause_q,
    input logic [NSRC-1:0]   mask_q
);
    tgt_e            tgt;
    logic            wr_cause;
    logic            wr_mask;
    logic            wr_other;
    logic [NSRC-1:0] prev_eff;
    logic [NSRC-1:0] below_id;

    assign tgt      = decode_target(bus_addr);
    assign wr_cause = bus_sel && bus_wr && (tgt == TGT_CAUSE);
    assign wr_mask  = bus_sel && bus_wr && (tgt == TGT_ENABLE);
    assign wr_other = bus_sel && bus_wr && (tgt == TGT_NONE);
    assign below_id = (NSRC'(1) << irq_id) - NSRC'(1);

    always_ff @(posedge clk) begin
        if (rst)
            prev_eff <= '0;
        else
            prev_eff <= cause_q & mask_q;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cause_q == '0 && mask_q == '0 && !irq_out && !irq_id_valid));

    assert_source_latch_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((cause_q & $past(src_req)) == $past(src_req)));

    assert_write_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_cause && src_req == '0) |=> ((cause_q & $past(bus_wdata)) == '0));

    assert_mask_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == $past(bus_wdata)));

    assert_irq_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (irq_out == |($past(cause_q) & $past(mask_q))));

    assert_lowest_id_R6: assert property (@(posedge clk) disable iff (rst)
        irq_id_valid |-> (prev_eff[irq_id] && ((prev_eff & below_id) == '0)));

    assert_id_zero_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !irq_id_valid |-> (irq_id == '0 && prev_eff == '0));

    assert_other_offset_R9: assert property (@(posedge clk) disable iff (rst)
        wr_other |=> ($stable(mask_q)));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind cic_top cic_checker #(.NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_req      (src_req),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_out      (irq_out),
    .irq_id       (irq_id),
    .irq_id_valid (irq_id_valid),
    .cause_q      (cause_q),
    .mask_q       (mask_q)
);

// File: tb/tb_cic_top.sv
module tb_cic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] mask;
        logic        irq;
        logic [4:0]  id;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 5'd0},
        '{32'h8000_0000, 32'h8000_0000, 1'b1, 5'd31},
        '{32'h0000_0F00, 32'h0000_0C00, 1'b1, 5'd10},
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0},
        '{32'h0001_0010, 32'hFFFF_0000, 1'b1, 5'd16},
        '{32'hAAAA_0000, 32'h5555_FFFF, 1'b0, 5'd0},
        '{32'hF000_0000, 32'h3000_0000, 1'b1, 5'd28}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [4:0]  irq_id;
    logic        irq_id_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;
    logic [31:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    cic_top #(.NSRC(NSRC)) dut (
        .clk(clk), .rst(rst), .src_req(src_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .irq_id(irq_id), .irq_id_valid(irq_id_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        chk("R1 irq_id_valid", 32'(irq_id_valid), 32'h0);
        chk("R1 irq_id", 32'(irq_id), 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rst = 1'b0;
        bus_read(4'h0, rv); chk("R1 cause", rv, 32'h0);
        bus_read(4'h4, rv); chk("R1 enable", rv, 32'h0);

        // Table walk: R2, R4, R5, R6
        for (int v = 0; v < NV; v++) begin
            bus_write(4'h4, VECS[v].mask);
            bus_read(4'h4, rv); chk("R4 enable readback", rv, VECS[v].mask);
            @(negedge clk); src_req = VECS[v].src;
            @(negedge clk);
            chk("R5 irq not yet", 32'(irq_out), 32'h0);
            @(negedge clk);
            chk("R5 irq_out", 32'(irq_out), 32'(VECS[v].irq));
            chk("R6 irq_id_valid", 32'(irq_id_valid), 32'(VECS[v].irq));
            chk("R6 irq_id", 32'(irq_id), 32'(VECS[v].id));
            bus_read(4'h0, rv); chk("R2 raw cause", rv, VECS[v].src);
            src_req = '0;
            bus_write(4'h0, 32'hFFFF_FFFF);
            bus_read(4'h0, rv); chk("R3 cause cleared", rv, 32'h0);
            chk("R5 irq low", 32'(irq_out), 32'h0);
        end

        // R2/R3: pulse latches, partial clear leaves zero-written bits
        bus_write(4'h4, 32'h0);
        @(negedge clk); src_req = 32'h0000_00F0;
        @(negedge clk); src_req = '0;
        bus_read(4'h0, rv); chk("R2 latched after drop", rv, 32'h0000_00F0);
        chk("R5 masked no irq", 32'(irq_out), 32'h0);
        bus_write(4'h0, 32'h0000_0030);
        bus_read(4'h0, rv); chk("R3 partial clear", rv, 32'h0000_00C0);

        // R5/R6: enable write while cause pending, irq one edge after mask update
        bus_write(4'h4, 32'h0000_0080);
        chk("R5 irq same edge", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R5 irq after mask", 32'(irq_out), 32'h1);
        chk("R6 id 7", 32'(irq_id), 32'd7);

        // R7: clear while source held
        @(negedge clk); src_req = 32'h0000_0008;
        bus_write(4'h0, 32'h0000_0008);
        bus_read(4'h0, rv); chk("R7 set wins", rv, 32'h0000_00C8);
        src_req = '0;

        // R8: quiesce sequence
        bus_write(4'h4, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R8 irq before quiesce", 32'(irq_out), 32'h1);
        bus_write(4'h4, 32'h0);
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, rv); chk("R8 cause zero", rv, 32'h0);
        bus_read(4'h4, rv); chk("R8 enable zero", rv, 32'h0);
        chk("R8 irq low", 32'(irq_out), 32'h0);

        // R9: unmapped offsets and byte-lane bits
        bus_write(4'h4, 32'h0000_1234);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'h4, rv); chk("R9 enable untouched", rv, 32'h0000_1234);
        bus_read(4'hC, rv); chk("R9 unmapped read", rv, 32'h0);
        bus_read(4'h6, rv); chk("R9 byte bits ignored", rv, 32'h0000_1234);
        bus_write(4'h7, 32'h0000_5678);
        bus_read(4'h4, rv); chk("R9 write byte bits ignored", rv, 32'h0000_5678);

        // R10: read data holds across writes
        bus_read(4'h4, held);
        bus_write(4'h4, 32'hDEAD_0000);
        @(negedge clk);
        chk("R10 rdata held", bus_rdata, held);

        finish_run();
    end
endmodule